// File: doc/BRIEF.md
# Real-Time Clock Event Flags and Interrupt Request

This block collects the events of a real-time clock and turns them into software-visible status and a single interrupt line. The counters, the oscillator and the alarm comparators sit elsewhere. They hand this block five one-cycle event pulses and three level "pending" signals. Each event pulse sets a sticky flag. That flag stays set until software reads the status word.

A control word holds one interrupt enable per event and a bit that mutes every interrupt while the core is halted for debug (the `emu_mode` input). The `irq` output is the OR, over all events, of flag AND enable. It is forced low when debug mode and the mute bit are both active.

Software reaches both words through a plain register port: address, read strobe, write strobe, write data and read data. Read data is registered. It appears in the cycle after the read strobe and holds until the next read. The port has no back-pressure, because every access finishes in one cycle.

Top module: `rtc_evt_core`

## Requirements
- R1: After reset, the control word is 0, every status flag is 0, `bus_rdata` is 0 and `irq` is low.
- R2: A write to the control address (0) stores bits 4..9. Reading the control word back returns those bits, and every other bit reads 0. The enables are: bit 4 day, bit 5 alarm, bit 6 day alarm, bit 7 stopwatch, bit 8 clock fail. Bit 9 is the debug mute.
- R3: A pulse on `evt_pulse[i]` sets status bit i. The bits are: 0 day, 1 alarm, 2 day alarm, 3 stopwatch, 4 clock fail (oscillator failed to start). The flag is set whatever the enable holds, and it stays set until a status read.
- R4: A read of the status address (1) returns the status word in the next cycle. The same read clears status bits 0..4.
- R5: Status bits 5..7 show `pend_in[0..2]` (write pending, alarm pending, day-alarm pending) as sampled at the read. A read does not clear them.
- R6: If an event pulse arrives in the same cycle as a status read, the read returns the flag's old value and the flag is left set afterwards.
- R7: A write to the status address has no effect on any flag.
- R8: `irq` is high exactly when some status bit i (i in 0..4) and its enable (control bit 4+i) are both 1.
- R9: While `emu_mode` is 1 and control bit 9 is 1, `irq` is low. When control bit 9 is 0, `emu_mode` has no effect on `irq`.
- R10: A read of any other address returns 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, held until the next read |
| evt_pulse | input | NUM_EVT | Event pulses: day, alarm, day alarm, stopwatch, clock fail |
| pend_in | input | NUM_PEND | Level pending inputs: write, alarm, day alarm |
| emu_mode | input | 1 | Core is in debug (emulation) mode |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks that events raised while their enable is off still appear in the status word. A design that gated the flag with the enable would read zeros there.

It places an event pulse in the very cycle of a status read. A design that let the clear win would lose that event. One that forwarded the pulse would report it early.

It reads the status word twice while the pending inputs are high. A clear that wrongly covered bits 5..7 would show up on the second read.

It also writes to the status address and to an unused address, then reads back. Finally, it toggles debug mode with the mute bit set and with it clear, to catch an interrupt that leaks through or is muted when it should not be.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  // Event flags and enables share one index order: day, alarm, day alarm,
  // stopwatch, clock fail.
  localparam int NUM_EVT       = 5;
  localparam int NUM_PEND      = 3;
  localparam int CTRL_EN_LSB   = 4;
  localparam int CTRL_MUTE_BIT = CTRL_EN_LSB + NUM_EVT;
  localparam int STAT_PEND_LSB = NUM_EVT;
  localparam int STAT_USED     = NUM_EVT + NUM_PEND;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl
  import rtc_evt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_EVT-1:0] en_o,
  output logic              mute_o,
  output logic [DATA_W-1:0] word_o
);
  logic [NUM_EVT-1:0] en_q;
  logic               mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mute_q <= 1'b0;
    end else if (wr_en) begin
      en_q   <= wdata[CTRL_EN_LSB +: NUM_EVT];
      mute_q <= wdata[CTRL_MUTE_BIT];
    end
  end

  always_comb begin
    word_o = '0;
    word_o[CTRL_EN_LSB +: NUM_EVT] = en_q;
    word_o[CTRL_MUTE_BIT]          = mute_q;
  end

  assign en_o   = en_q;
  assign mute_o = mute_q;
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] flags_o
);
  // One sticky cell per event; a new event outranks a clear in the same cycle.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (evt_i[i])   flag_q <= 1'b1;
      else if (clr_i)      flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
(
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic               emu_i,
  input  logic               mute_i,
  output logic               irq_o
);
  logic any_req;
  logic silenced;

  always_comb begin
    any_req  = |(flags_i & en_i);
    silenced = emu_i & mute_i;
    irq_o    = any_req & ~silenced;
  end
endmodule

// File: rtl/rtc_evt_rdmux.sv
module rtc_evt_rdmux
  import rtc_evt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  reg_sel_e            sel,
  input  logic [DATA_W-1:0]   ctrl_word,
  input  logic [NUM_EVT-1:0]  flags,
  input  logic [NUM_PEND-1:0] pend,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    stat_word = '0;
    stat_word[0 +: NUM_EVT]              = flags;
    stat_word[STAT_PEND_LSB +: NUM_PEND] = pend;
    unique case (sel)
      SEL_CTRL: pick = ctrl_word;
      SEL_STAT: pick = stat_word;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= pick;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rtc_evt_core.sv
module rtc_evt_core
  import rtc_evt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  input  logic [NUM_PEND-1:0] pend_in,
  input  logic                emu_mode,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  reg_sel_e           sel;
  logic               ctrl_wr;
  logic               stat_rd;
  logic [NUM_EVT-1:0] en_v;
  logic               mute_v;
  logic [DATA_W-1:0]  ctrl_word;
  logic [NUM_EVT-1:0] flags_q;

  always_comb begin
    if (bus_addr == A_CTRL)      sel = SEL_CTRL;
    else if (bus_addr == A_STAT) sel = SEL_STAT;
    else                         sel = SEL_NONE;
    ctrl_wr = bus_wr & (sel == SEL_CTRL);
    stat_rd = bus_rd & (sel == SEL_STAT);
  end

  rtc_evt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata),
    .en_o   (en_v),
    .mute_o (mute_v),
    .word_o (ctrl_word)
  );

  rtc_evt_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_pulse),
    .clr_i   (stat_rd),
    .flags_o (flags_q)
  );

  rtc_evt_irq u_irq (
    .flags_i (flags_q),
    .en_i    (en_v),
    .emu_i   (emu_mode),
    .mute_i  (mute_v),
    .irq_o   (irq)
  );

  rtc_evt_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .sel       (sel),
    .ctrl_word (ctrl_word),
    .flags     (flags_q),
    .pend      (pend_in),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/rtc_evt_core_chk.sv
module rtc_evt_core_chk
  import rtc_evt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int STAT_ADDR = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_EVT-1:0]  evt_pulse,
  input logic [NUM_PEND-1:0] pend_in,
  input logic                emu_mode,
  input logic                irq,
  input logic [NUM_EVT-1:0]  flags_q,
  input logic [NUM_EVT-1:0]  en_v,
  input logic                mute_v
);
  logic is_stat;
  assign is_stat = (bus_addr == ADDR_W'(STAT_ADDR));

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bus_rdata == '0) && !irq && (flags_q == '0));

  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flags_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_flag_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd && is_stat) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && is_stat) |-> ((flags_q & ~$past(evt_pulse)) == '0));

  p_pend_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && is_stat) |->
      (bus_rdata[STAT_PEND_LSB +: NUM_PEND] == $past(pend_in)));

  p_stat_wr_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr && is_stat && !bus_rd) && ($past(evt_pulse) == '0)) |-> $stable(flags_q));

  p_no_req_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & en_v) == '0) |-> !irq);

  p_emu_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && mute_v) |-> !irq);
endmodule

bind rtc_evt_core rtc_evt_core_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
  .pend_in(pend_in), .emu_mode(emu_mode), .irq(irq),
  .flags_q(flags_q), .en_v(en_v), .mute_v(mute_v)
);

// File: tb/rtc_evt_core_test.sv
module rtc_evt_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  evt_pulse = '0;
  logic [2:0]  pend_in = '0;
  logic        emu_mode = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rtc_evt_core uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .pend_in(pend_in), .emu_mode(emu_mode), .irq(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued at a posedge shows up by the following negedge.
  always @(posedge clk) rd_seen <= bus_rd && rst_n;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%h expected=<none>", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag,
                    input logic [4:0] evt = '0);
    bus_addr = a; bus_rd = 1'b1; evt_pulse = evt;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [4:0] m);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({15'd0, irq}, 16'd0, "R1 irq at reset");
    chk(bus_rdata, 16'd0, "R1 rdata at reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, 16'h0000, "R1 ctrl after reset");
    rd(4'd1, 16'h0000, "R1 status after reset");

    wr(4'd0, 16'hFFFF);
    rd(4'd0, 16'h03F0, "R2 ctrl keeps bits 4..9");
    wr(4'd0, 16'h0000);
    rd(4'd0, 16'h0000, "R2 ctrl cleared");

    pulse(5'b10101);
    chk({15'd0, irq}, 16'd0, "R8 no irq with enables off");
    @(negedge clk);
    rd(4'd1, 16'h0015, "R3 flags set with enables off");
    rd(4'd1, 16'h0000, "R4 flags cleared by read");

    pend_in = 3'b101;
    rd(4'd1, 16'h00A0, "R5 pending mirror");
    rd(4'd1, 16'h00A0, "R5 pending survives read");
    pend_in = 3'b010;
    rd(4'd1, 16'h0040, "R5 pending follows input");
    pend_in = 3'b000;

    pulse(5'b00001);
    wr(4'd1, 16'hFFFF);
    wr(4'd1, 16'h0000);
    rd(4'd1, 16'h0001, "R7 status write ignored");

    pulse(5'b01000);
    rd(4'd1, 16'h0008, "R6 read returns old value", 5'b00010);
    rd(4'd1, 16'h0002, "R6 coincident event kept");
    rd(4'd1, 16'h0000, "R4 cleared after coincident");

    wr(4'd0, 16'h0020);
    pulse(5'b00001);
    chk({15'd0, irq}, 16'd0, "R8 disabled event no irq");
    pulse(5'b00010);
    chk({15'd0, irq}, 16'd1, "R8 enabled event raises irq");
    rd(4'd1, 16'h0003, "R3 both flags");
    chk({15'd0, irq}, 16'd0, "R8 irq drops after read");

    wr(4'd0, 16'h0220);
    emu_mode = 1'b1;
    pulse(5'b00010);
    chk({15'd0, irq}, 16'd0, "R9 muted in debug mode");
    emu_mode = 1'b0;
    #1;
    chk({15'd0, irq}, 16'd1, "R9 irq outside debug mode");
    wr(4'd0, 16'h0020);
    emu_mode = 1'b1;
    #1;
    chk({15'd0, irq}, 16'd1, "R9 mute bit clear");
    emu_mode = 1'b0;
    rd(4'd1, 16'h0002, "R4 clear alarm");

    wr(4'd3, 16'hFFFF);
    rd(4'd3, 16'h0000, "R10 unused address reads zero");
    rd(4'd0, 16'h0020, "R10 ctrl untouched");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending reads", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule